// File: doc/BRIEF.md
# Interleaved Multi-Bank Scratch Memory

This block is an on-chip word memory built from several independent banks, each of which can do one read or one write per clock. A set of load/store ports sits in front of the banks. The bank that serves a request is picked by the least significant bits of the word address. The rest of the address selects a word inside that bank. Consecutive word addresses therefore land in different banks. Ports that walk through memory in step with each other, each on its own bank, all proceed every cycle.

Each bank has its own round-robin arbiter. When two or more ports aim at the same bank in one cycle, that arbiter accepts exactly one of them and holds the rest off by keeping their ready low. A port that loses keeps its request unchanged until it is accepted. Ports whose banks are uncontested are never held. A read returns its word on the issuing port one cycle after acceptance. Writes produce no response.

Top module: `banked_mem_top`

## Requirements
- R1: The bank of a request is `reqAddr[BANK_W-1:0]` (bits 2:0 with eight banks), and the word inside the bank is `reqAddr[ADDR_W-1:BANK_W]`.
- R2: When the valid requests of a cycle address pairwise distinct banks, all of them see `reqReady` high in that cycle, so every port can complete one access per clock.
- R3: Each bank accepts at most one request per cycle, and a bank with at least one valid request accepts exactly one of them.
- R4: `reqReady` of a port is low in any cycle in which its `reqValid` is low.
- R5: A valid request whose bank no other valid port addresses in that cycle is accepted in that same cycle.
- R6: Round-robin order: after a bank accepts port g, port (g+1) mod NUM_PORTS has first claim on that bank. Four ports contending for one bank are accepted one per cycle in cyclically ascending port order, and two ports that keep contending alternate.
- R7: A request held valid and unchanged is accepted no more than NUM_PORTS-1 cycles after it is first presented.
- R8: An accepted read (`reqWrite` low) raises `rspValid` on the same port exactly one cycle later, with `rspData` holding the word at that address. An accepted write produces no `rspValid`.
- R9: A write stores `reqWdata` at its address so that later reads return it. Two addresses that differ only in bank bits or only in word bits do not alias.
- R10: While reset is low and in the first cycle after it, `rspValid` is low on every port, and with no valid requests every `reqReady` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_PORTS | Request present, one bit per port |
| reqReady | output | NUM_PORTS | Request accepted this cycle, one bit per port |
| reqWrite | input | NUM_PORTS | 1 = write, 0 = read, per port |
| reqAddr | input | NUM_PORTS*ADDR_W | Word addresses, port p at bits [p*ADDR_W +: ADDR_W] |
| reqWdata | input | NUM_PORTS*DATA_W | Write data, port p at bits [p*DATA_W +: DATA_W] |
| rspValid | output | NUM_PORTS | Read data returned this cycle, per port |
| rspData | output | NUM_PORTS*DATA_W | Read data, port p at bits [p*DATA_W +: DATA_W] |

## Verification
Checked every cycle by the assertions:
- ready never appears without valid.
- A bank never serves two ports at once and never idles while it is requested.
- A lone request is never stalled.
- The port after the last winner wins next if it asks.
- No held request waits NUM_PORTS cycles.
- A read response follows exactly one cycle after each accepted read and after nothing else.

Only the bench scenarios can show the rest:
- Interleaved sequential streams from four ports run at one access per port per clock.
- A four-way and a two-way collision on one bank are served in rotating order.
- The returned words are those written, including at addresses that differ only in bank or word bits.

// File: rtl/bankmem_pkg.sv
package bankmem_pkg;
  // Width of the selector fields carried in the strobe structs; it bounds
  // NUM_PORTS and NUM_BANKS to 256.
  localparam int SEL_W = 8;

  // Per-bank command from the control to the datapath.
  typedef struct packed {
    logic             rdEn;
    logic             wrEn;
    logic [SEL_W-1:0] portSel;
  } bankStb_t;

  // Per-port response command from the control to the datapath.
  typedef struct packed {
    logic             rdGo;
    logic [SEL_W-1:0] bankSel;
  } portStb_t;
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] req,
  output logic [NUM_PORTS-1:0] gnt,
  output logic [PORT_W-1:0]    gntIdx,
  output logic                 gntAny
);
  logic [PORT_W-1:0] prioPtr;
  logic [PORT_W-1:0] probe;

  // Scan from the priority pointer upward, wrapping; first requester wins.
  always_comb begin
    gnt    = '0;
    gntIdx = '0;
    gntAny = 1'b0;
    probe  = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      probe = prioPtr + PORT_W'(i);
      if (!gntAny && req[probe]) begin
        gntAny      = 1'b1;
        gnt[probe]  = 1'b1;
        gntIdx      = probe;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       prioPtr <= '0;
    else if (gntAny) prioPtr <= gntIdx + PORT_W'(1);
  end

  // Checker state: successor of the previous winner.
  logic [PORT_W-1:0] chkSucc;
  logic              chkHad;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkSucc <= '0;
      chkHad  <= 1'b0;
    end else begin
      chkSucc <= gntIdx + PORT_W'(1);
      chkHad  <= gntAny;
    end
  end

  p_grant_subset_r3: assert property (@(posedge clk) disable iff (!rstN)
    (gnt & ~req) == '0);
  p_successor_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    (chkHad && req[chkSucc]) |-> gnt[chkSucc]);
endmodule

// File: rtl/bank_arb_ctrl.sv
module bank_arb_ctrl
  import bankmem_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 10,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int PORT_W = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] reqValid,
  input  logic [NUM_PORTS-1:0] reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr [NUM_PORTS],
  output logic [NUM_PORTS-1:0] reqReady,
  output bankStb_t             bankStb [NUM_BANKS],
  output portStb_t             portStb [NUM_PORTS]
);
  logic [BANK_W-1:0]    reqBank [NUM_PORTS];
  logic [NUM_PORTS-1:0] bankReq [NUM_BANKS];
  logic [NUM_PORTS-1:0] bankGnt [NUM_BANKS];
  logic [PORT_W-1:0]    gntIdx  [NUM_BANKS];
  logic                 gntAny  [NUM_BANKS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign reqBank[p]         = reqAddr[p][BANK_W-1:0];
    assign portStb[p].rdGo    = reqReady[p] & ~reqWrite[p];
    assign portStb[p].bankSel = SEL_W'(reqBank[p]);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_comb begin
      for (int p = 0; p < NUM_PORTS; p++)
        bankReq[b][p] = reqValid[p] && (reqBank[p] == BANK_W'(b));
    end

    rr_arbiter #(.NUM_PORTS(NUM_PORTS)) arb_i (
      .clk    (clk),
      .rstN   (rstN),
      .req    (bankReq[b]),
      .gnt    (bankGnt[b]),
      .gntIdx (gntIdx[b]),
      .gntAny (gntAny[b])
    );

    assign bankStb[b].wrEn    = gntAny[b] &  reqWrite[gntIdx[b]];
    assign bankStb[b].rdEn    = gntAny[b] & ~reqWrite[gntIdx[b]];
    assign bankStb[b].portSel = SEL_W'(gntIdx[b]);
  end

  always_comb begin
    reqReady = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      for (int b = 0; b < NUM_BANKS; b++)
        reqReady[p] = reqReady[p] | bankGnt[b][p];
  end

  // ---------------- checks ----------------
  logic [NUM_PORTS-1:0] chkAlone;
  logic [NUM_PORTS-1:0] chkServed [NUM_BANKS];
  logic [NUM_PORTS-1:0] chkAsked  [NUM_BANKS];
  logic [7:0]           chkWait   [NUM_PORTS];

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      chkAlone[p] = reqValid[p];
      for (int q = 0; q < NUM_PORTS; q++)
        if (q != p && reqValid[q] && reqAddr[q][BANK_W-1:0] == reqAddr[p][BANK_W-1:0])
          chkAlone[p] = 1'b0;
    end
    for (int b = 0; b < NUM_BANKS; b++)
      for (int p = 0; p < NUM_PORTS; p++) begin
        chkServed[b][p] = reqReady[p] && (reqAddr[p][BANK_W-1:0] == BANK_W'(b));
        chkAsked[b][p]  = reqValid[p] && (reqAddr[p][BANK_W-1:0] == BANK_W'(b));
      end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pchk
    always_ff @(posedge clk) begin
      if (!rstN)                          chkWait[p] <= '0;
      else if (!reqValid[p] || reqReady[p]) chkWait[p] <= '0;
      else if (chkWait[p] != 8'hFF)       chkWait[p] <= chkWait[p] + 8'd1;
    end

    p_ready_needs_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
      !reqValid[p] |-> !reqReady[p]);
    p_lone_never_stalls_r5: assert property (@(posedge clk) disable iff (!rstN)
      chkAlone[p] |-> reqReady[p]);
    p_bounded_wait_r7: assert property (@(posedge clk) disable iff (!rstN)
      int'(chkWait[p]) <= NUM_PORTS - 1);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bchk
    p_one_per_bank_r3: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(chkServed[b]));
    p_busy_bank_serves_r3: assert property (@(posedge clk) disable iff (!rstN)
      (|chkAsked[b]) |-> (|chkServed[b]));
  end
endmodule

// File: rtl/bank_datapath.sv
module bank_datapath
  import bankmem_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int PORT_W = $clog2(NUM_PORTS),
  localparam int IDX_W  = ADDR_W - BANK_W,
  localparam int DEPTH  = 1 << IDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    reqAddr  [NUM_PORTS],
  input  logic [DATA_W-1:0]    reqWdata [NUM_PORTS],
  input  bankStb_t             bankStb  [NUM_BANKS],
  input  portStb_t             portStb  [NUM_PORTS],
  output logic [NUM_PORTS-1:0] rspValid,
  output logic [DATA_W-1:0]    rspData  [NUM_PORTS]
);
  logic [DATA_W-1:0] bankRd  [NUM_BANKS];
  logic [BANK_W-1:0] rspBank [NUM_PORTS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] store [DEPTH];
    logic [PORT_W-1:0] sel;
    logic [IDX_W-1:0]  idx;

    assign sel = bankStb[b].portSel[PORT_W-1:0];
    assign idx = reqAddr[sel][ADDR_W-1:BANK_W];

    always_ff @(posedge clk) begin
      if (bankStb[b].wrEn) store[idx] <= reqWdata[sel];
      if (bankStb[b].rdEn) bankRd[b]  <= store[idx];
    end

    p_single_op_r3: assert property (@(posedge clk) disable iff (!rstN)
      !(bankStb[b].rdEn && bankStb[b].wrEn));
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rspValid[p] <= 1'b0;
        rspBank[p]  <= '0;
      end else begin
        rspValid[p] <= portStb[p].rdGo;
        if (portStb[p].rdGo) rspBank[p] <= portStb[p].bankSel[BANK_W-1:0];
      end
    end
    assign rspData[p] = bankRd[rspBank[p]];
  end
endmodule

// File: rtl/banked_mem_top.sv
module banked_mem_top
  import bankmem_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_PORTS-1:0]          reqValid,
  output logic [NUM_PORTS-1:0]          reqReady,
  input  logic [NUM_PORTS-1:0]          reqWrite,
  input  logic [NUM_PORTS*ADDR_W-1:0]   reqAddr,
  input  logic [NUM_PORTS*DATA_W-1:0]   reqWdata,
  output logic [NUM_PORTS-1:0]          rspValid,
  output logic [NUM_PORTS*DATA_W-1:0]   rspData
);
  logic [ADDR_W-1:0] addrArr  [NUM_PORTS];
  logic [DATA_W-1:0] wdataArr [NUM_PORTS];
  logic [DATA_W-1:0] rdataArr [NUM_PORTS];
  bankStb_t          bankStb  [NUM_BANKS];
  portStb_t          portStb  [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_unpack
    assign addrArr[p]                  = reqAddr[p*ADDR_W +: ADDR_W];
    assign wdataArr[p]                 = reqWdata[p*DATA_W +: DATA_W];
    assign rspData[p*DATA_W +: DATA_W] = rdataArr[p];
  end

  bank_arb_ctrl #(
    .NUM_PORTS(NUM_PORTS), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (addrArr),
    .reqReady (reqReady),
    .bankStb  (bankStb),
    .portStb  (portStb)
  );

  bank_datapath #(
    .NUM_PORTS(NUM_PORTS), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqAddr  (addrArr),
    .reqWdata (wdataArr),
    .bankStb  (bankStb),
    .portStb  (portStb),
    .rspValid (rspValid),
    .rspData  (rdataArr)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rchk
    p_read_response_r8: assert property (@(posedge clk) disable iff (!rstN)
      rspValid[p] == $past(reqValid[p] && reqReady[p] && !reqWrite[p]));
  end
endmodule

// File: tb/banked_mem_top_tb_top.sv
module banked_mem_top_tb_top;
  localparam int NP = 4;
  localparam int NB = 8;
  localparam int AW = 10;
  localparam int DW = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NP-1:0]   reqValid = '0;
  logic [NP-1:0]   reqReady;
  logic [NP-1:0]   reqWrite = '0;
  logic [NP*AW-1:0] reqAddr = '0;
  logic [NP*DW-1:0] reqWdata = '0;
  logic [NP-1:0]   rspValid;
  logic [NP*DW-1:0] rspData;

  always #10 clk = ~clk;  // 50 MHz

  banked_mem_top #(.NUM_PORTS(NP), .NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cycleCnt = 0;
  logic [DW-1:0] shadow [int];
  logic [DW-1:0] expQ [NP][$];
  int lastAcc [NP];

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: caller is at a negedge; returns at the negedge after acceptance.
  task automatic access(input int p, input bit wr, input int addr, input logic [DW-1:0] data);
    reqValid[p] = 1'b1;
    reqWrite[p] = wr;
    reqAddr[p*AW +: AW] = AW'(addr);
    reqWdata[p*DW +: DW] = data;
    forever begin
      #2;
      if (reqReady[p]) break;
      @(negedge clk);
    end
    lastAcc[p] = cycleCnt;
    if (wr) shadow[addr] = data;
    else    expQ[p].push_back(shadow[addr]);
    @(negedge clk);
    reqValid[p] = 1'b0;
  endtask

  // Monitor / scoreboard (R8, R9).
  always @(negedge clk) begin
    if (rstN) begin
      for (int p = 0; p < NP; p++) begin
        if (rspValid[p]) begin
          if (expQ[p].size() == 0) check(1'b0, "R8 unexpected response", p, -1);
          else begin
            logic [DW-1:0] e;
            e = expQ[p].pop_front();
            check(rspData[p*DW +: DW] == e, "R8 R9 read data", rspData[p*DW +: DW], e);
          end
        end
      end
    end
  end

  task automatic stream(input int p, input bit wr, input int n, output int first);
    for (int k = 0; k < n; k++) begin
      access(p, wr, 4*k + p, 32'hA500_0000 + 32'(p*256 + k));
      if (k == 0) first = lastAcc[p];
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", cycleCnt, 0);
    summary();
  end

  initial begin
    int f [NP];
    int c [NP];
    repeat (3) @(negedge clk);
    #2;
    check(rspValid == '0, "R10 rspValid in reset", rspValid, 0);
    check(reqReady == '0, "R10 ready in reset", reqReady, 0);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    check(rspValid == '0 && reqReady == '0, "R10 after reset", {rspValid, reqReady}, 0);
    // R4: stale address and write bits with valid low give no ready.
    reqWrite = '1;
    reqAddr  = {10'd5, 10'd5, 10'd5, 10'd5};
    #1;
    check(reqReady == '0, "R4 idle ready", reqReady, 0);
    reqWrite = '0;
    @(negedge clk);

    // R2 / R1: interleaved sequential write streams, then read streams.
    fork
      stream(0, 1'b1, 16, f[0]);
      stream(1, 1'b1, 16, f[1]);
      stream(2, 1'b1, 16, f[2]);
      stream(3, 1'b1, 16, f[3]);
    join
    for (int p = 0; p < NP; p++)
      check(lastAcc[p] - f[p] == 15 && f[p] == f[0], "R2 full-rate writes", lastAcc[p] - f[p], 15);
    fork
      stream(0, 1'b0, 16, f[0]);
      stream(1, 1'b0, 16, f[1]);
      stream(2, 1'b0, 16, f[2]);
      stream(3, 1'b0, 16, f[3]);
    join
    for (int p = 0; p < NP; p++)
      check(lastAcc[p] - f[p] == 15 && f[p] == f[0], "R2 R5 full-rate reads", lastAcc[p] - f[p], 15);
    repeat (2) @(negedge clk);

    // R1 R9: addresses differing only in bank bits or only in word bits.
    access(1, 1'b1, 8,   32'h1111_0008);
    access(1, 1'b1, 1,   32'h2222_0001);
    access(1, 1'b1, 9,   32'h3333_0009);
    access(1, 1'b0, 8,   32'h0);
    access(1, 1'b0, 1,   32'h0);
    access(1, 1'b0, 9,   32'h0);
    @(negedge clk);

    // Prefill bank 3 and bank 5 words for the conflict reads.
    for (int p = 0; p < NP; p++) access(0, 1'b1, 3 + 8*(p+10), 32'hC300_0000 + 32'(p));
    for (int k = 0; k < 6; k++) access(2, 1'b1, 5 + 8*(k+10), 32'hC500_0000 + 32'(k));
    @(negedge clk);

    // R3 R6 R7: four ports hit bank 3 together.
    fork
      access(0, 1'b0, 3 + 8*10, 0);
      access(1, 1'b0, 3 + 8*11, 0);
      access(2, 1'b0, 3 + 8*12, 0);
      access(3, 1'b0, 3 + 8*13, 0);
    join
    begin
      int lo, hi, first;
      lo = lastAcc[0]; hi = lastAcc[0]; first = 0;
      for (int p = 0; p < NP; p++) begin
        c[p] = lastAcc[p];
        if (c[p] < lo) begin lo = c[p]; first = p; end
        if (c[p] > hi) hi = c[p];
      end
      check(hi - lo == 3, "R3 R7 four-way span", hi - lo, 3);
      for (int i = 1; i < NP; i++)
        check(c[(first + i) % NP] == lo + i, "R6 rotating order", c[(first + i) % NP] - lo, i);
    end
    @(negedge clk);

    // R6: ports 0 and 2 keep contending for bank 5; grants alternate.
    begin
      int a0 [3];
      int a2 [3];
      fork
        for (int k = 0; k < 3; k++) begin access(0, 1'b0, 5 + 8*(10+k), 0); a0[k] = lastAcc[0]; end
        for (int k = 0; k < 3; k++) begin access(2, 1'b0, 5 + 8*(13+k), 0); a2[k] = lastAcc[2]; end
      join
      for (int k = 1; k < 3; k++) begin
        check(a0[k] - a0[k-1] == 2, "R6 port0 alternation", a0[k] - a0[k-1], 2);
        check(a2[k] - a2[k-1] == 2, "R6 port2 alternation", a2[k] - a2[k-1], 2);
      end
      check((a0[0] > a2[0] ? a0[0] - a2[0] : a2[0] - a0[0]) == 1, "R3 R7 pair offset",
            a0[0] - a2[0], 1);
    end

    repeat (3) @(negedge clk);
    for (int p = 0; p < NP; p++)
      check(expQ[p].size() == 0, "R8 all reads answered", expQ[p].size(), 0);
    summary();
  end
endmodule